// File: doc/BRIEF.md
# CTS Change Interrupt with Edge-Triggered Clear

This block raises an interrupt whenever a UART's clear-to-send input changes level. The input is first brought into the local clock through a synchroniser. A transition in either direction then sets a raw status flag. Software reads that flag, and also the flag after an enable mask, through a small register port that runs in the same clock domain.

The flag is cleared through a write-only clear register. A write does not clear the flag by its level. It loads an internal clear latch, and only a 0-to-1 change of that latch removes the flag. Hardware drops the latch back to 0 once the flag is low. If a CTS change and a clear arrive in the same cycle, the set wins and the flag stays high. The latch is then left at 1, and any further writes of 1 do nothing. Software recovers by writing 0, which re-arms the latch, and then writing 1 on a later cycle. The latch is brought out on a port so a test can observe it.

Top module: `cts_change_irq`

## Requirements
- R1: During reset, and after it, the raw status, clear latch and mask are 0. The synchroniser is loaded with the current CTS level during reset, so a CTS input held high through reset sets no status.
- R2: A CTS change in either direction sets the raw status. If the change is applied before clock edge k, the status is seen high after edge k+2 and is still low after edge k+1.
- R3: A write of 1 to bit 1 at offset 2 (the clear register) while the latch is 0, with no CTS change in that cycle, clears the raw status and sets the latch after the same edge.
- R4: A write of 1 to the clear register while the latch is already 1 leaves the raw status unchanged.
- R5: With no write to the clear register, the latch returns to 0 one edge after the raw status is 0.
- R6: If a CTS change sets the status on the same edge that a clear takes effect, the raw status stays 1 and the latch stays 1.
- R7: A write of 0 to bit 1 of the clear register sets the latch to 0. A write of 1 on the next cycle then clears the raw status.
- R8: Bit 1 at offset 1 is a read/write mask. The interrupt output is high exactly when both the raw status and the mask are 1.
- R9: Reads are combinational. Offset 0 returns the raw status in bit 1, offset 1 returns the mask in bit 1, and offset 2 and every other bit read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_in | input | 1 | Asynchronous clear-to-send level |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | DATA_W | Read data for rd_addr |
| raw_status | output | 1 | Raw CTS-change flag |
| irq_out | output | 1 | Masked interrupt |
| clear_latch | output | 1 | Internal clear latch, for test |

## Verification
A CTS change reaches the raw status on the third edge after it is applied. A write to the mask or clear register takes effect on the edge that samples it. The latch self-reset follows one edge after the status reads 0. The read data and interrupt output follow the registers with no further delay. The bench drives inputs on falling edges and steps a behavioural model on each rising edge. It compares all outputs at the next falling edge. The directed scenarios count edges exactly: the collision case places the clear write on the third edge after the CTS toggle, so that both events land together.

// File: rtl/cts_irq_pkg.sv
package cts_irq_pkg;

    // Register offsets; bit position of the flag inside each register.
    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_MASK   = 1;
    localparam int unsigned OFS_CLEAR  = 2;
    localparam int unsigned FLAG_BIT   = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_CLEAR
    } reg_sel_e;

    // One-bit register load request.
    typedef struct packed {
        logic load;
        logic value;
    } bit_load_t;

    function automatic reg_sel_e decode_ofs(input int unsigned ofs);
        case (ofs)
            OFS_STATUS: decode_ofs = SEL_STATUS;
            OFS_MASK:   decode_ofs = SEL_MASK;
            OFS_CLEAR:  decode_ofs = SEL_CLEAR;
            default:    decode_ofs = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cts_edge_sync.sv
module cts_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic change
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {DEPTH{async_in}};
        else     chain_q[0] <= async_in;
    end

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst) chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    // Compare the last two synchronised samples.
    assign change = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/cts_clear_latch.sv
module cts_clear_latch
    import cts_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bit_load_t wr,
    input  logic      status_q,
    output logic      latch_q,
    output logic      clr_evt
);
    // A clear happens only when the latch goes from 0 to 1.
    assign clr_evt = wr.load && wr.value && !latch_q;

    always_ff @(posedge clk) begin
        if (rst)            latch_q <= 1'b0;
        else if (wr.load)   latch_q <= wr.value;
        else if (!status_q) latch_q <= 1'b0;
    end
endmodule

// File: rtl/cts_status_reg.sv
module cts_status_reg
    import cts_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      set_evt,
    input  logic      clr_evt,
    input  bit_load_t mask_wr,
    output logic      status_q,
    output logic      mask_q,
    output logic      irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
            mask_q   <= 1'b0;
        end else begin
            if (set_evt)      status_q <= 1'b1;   // set has priority
            else if (clr_evt) status_q <= 1'b0;
            if (mask_wr.load) mask_q <= mask_wr.value;
        end
    end

    assign irq = status_q & mask_q;
endmodule

// File: rtl/cts_change_irq.sv
module cts_change_irq
    import cts_irq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cts_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              raw_status,
    output logic              irq_out,
    output logic              clear_latch
);
    reg_sel_e  wr_sel, rd_sel;
    bit_load_t clr_wr, mask_wr;
    logic      cts_change, clr_evt, status_q, mask_q;

    assign wr_sel = decode_ofs(int'(unsigned'(wr_addr)));
    assign rd_sel = decode_ofs(int'(unsigned'(rd_addr)));

    always_comb begin
        clr_wr.load   = wr_en && (wr_sel == SEL_CLEAR);
        clr_wr.value  = wr_data[FLAG_BIT];
        mask_wr.load  = wr_en && (wr_sel == SEL_MASK);
        mask_wr.value = wr_data[FLAG_BIT];
    end

    cts_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cts_in),
        .change   (cts_change)
    );

    cts_clear_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .wr       (clr_wr),
        .status_q (status_q),
        .latch_q  (clear_latch),
        .clr_evt  (clr_evt)
    );

    cts_status_reg u_status (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (cts_change),
        .clr_evt  (clr_evt),
        .mask_wr  (mask_wr),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq      (irq_out)
    );

    assign raw_status = status_q;

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_STATUS: rd_data[FLAG_BIT] = status_q;
            SEL_MASK:   rd_data[FLAG_BIT] = mask_q;
            default:    rd_data = '0;   // clear register is write-only
        endcase
    end
endmodule

// File: rtl/cts_change_irq_chk.sv
module cts_change_irq_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              change,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              raw_status,
    input logic              clear_latch,
    input logic              irq_out
);
    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == ADDR_W'(2));

    a_r2_change_sets: assert property (@(posedge clk) disable iff (rst)
        change |=> raw_status);

    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && wr_data[1] && !clear_latch && !change) |=> (!raw_status && clear_latch));

    a_r4_stuck_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && wr_data[1] && clear_latch && raw_status) |=> raw_status);

    a_r5_latch_self_reset: assert property (@(posedge clk) disable iff (rst)
        (!raw_status && !clr_wr) |=> !clear_latch);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (change && clr_wr && wr_data[1] && !clear_latch) |=> (raw_status && clear_latch));

    a_r7_zero_rearms: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !wr_data[1]) |=> !clear_latch);

    a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> raw_status);
endmodule

bind cts_change_irq cts_change_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .change      (cts_change),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .raw_status  (raw_status),
    .clear_latch (clear_latch),
    .irq_out     (irq_out)
);

// File: tb/cts_change_irq_test.sv
`timescale 1ns/1ps
module cts_change_irq_test;
    localparam int  ADDR_W = 4;
    localparam int  DATA_W = 16;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cts_in = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              raw_status, irq_out, clear_latch;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cts_change_irq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .cts_in(cts_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .raw_status(raw_status), .irq_out(irq_out),
        .clear_latch(clear_latch)
    );

    // Behavioural reference: history of sampled CTS levels plus flag state.
    bit hist[$] = '{1'b1, 1'b1, 1'b1};
    bit m_st = 0, m_lt = 0, m_mk = 0;

    always @(posedge clk) begin
        bit set_ev, clr_ev, wclr, wmsk;
        if (rst) begin
            hist = '{cts_in, cts_in, cts_in};
            m_st = 0; m_lt = 0; m_mk = 0;
        end else begin
            set_ev = hist[1] != hist[2];
            wclr   = wr_en && wr_addr == 2;
            wmsk   = wr_en && wr_addr == 1;
            clr_ev = wclr && wr_data[1] && !m_lt;
            if (wclr)       m_lt = wr_data[1];
            else if (!m_st) m_lt = 0;
            if (set_ev)      m_st = 1;
            else if (clr_ev) m_st = 0;
            if (wmsk) m_mk = wr_data[1];
            hist.push_front(cts_in);
            void'(hist.pop_back());
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        int exp_rd;
        if (!rst && !finished) begin
            exp_rd = 0;
            if (rd_addr == 0) exp_rd = m_st ? 2 : 0;
            if (rd_addr == 1) exp_rd = m_mk ? 2 : 0;
            check("R2", "model raw_status", raw_status, m_st);
            check("R5", "model clear_latch", clear_latch, m_lt);
            check("R8", "model irq_out", irq_out, m_st && m_mk);
            check("R9", "model rd_data", rd_data, exp_rd);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1; wr_addr = ADDR_W'(addr); wr_data = DATA_W'(data);
        tick();
        wr_en = 0; wr_data = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); #1;
        tick(); tick();
        rst = 0;
        tick(); tick();
        // R1: CTS held high through reset produces no status.
        check("R1", "status after reset", raw_status, 0);
        check("R1", "latch after reset", clear_latch, 0);
        rd_addr = 1; #1;
        check("R1", "mask after reset", rd_data, 0);

        // R2: falling CTS, status due after third edge.
        cts_in = 0;
        tick(); tick();
        check("R2", "status one edge early", raw_status, 0);
        tick();
        check("R2", "status after falling change", raw_status, 1);
        check("R8", "irq with mask off", irq_out, 0);
        wr(1, 2);
        check("R8", "irq with mask on", irq_out, 1);
        rd_addr = 0; #1;
        check("R9", "status read", rd_data, 2);
        rd_addr = 2; #1;
        check("R9", "clear register reads zero", rd_data, 0);

        // R3 / R5: normal clear, then latch self-reset.
        wr(2, 2);
        check("R3", "status after clear", raw_status, 0);
        check("R3", "latch after clear", clear_latch, 1);
        tick();
        check("R5", "latch self-reset", clear_latch, 0);

        // R2 / R6: rising CTS colliding with a clear write.
        cts_in = 1;
        tick(); tick();
        wr(2, 2);
        check("R6", "status kept on collision", raw_status, 1);
        check("R6", "latch stuck at 1", clear_latch, 1);
        tick();
        // R4: repeated write of 1 has no effect.
        wr(2, 2);
        check("R4", "status still stuck", raw_status, 1);
        check("R4", "latch still 1", clear_latch, 1);

        // R7: write 0, then 1 on the following cycle.
        wr(2, 0);
        check("R7", "latch re-armed", clear_latch, 0);
        check("R7", "status held by write 0", raw_status, 1);
        wr(2, 2);
        check("R7", "status cleared after re-arm", raw_status, 0);

        // R8: mask off blocks irq on a fresh change.
        wr(1, 0);
        cts_in = 0;
        tick(); tick(); tick();
        check("R8", "status set, mask off", raw_status, 1);
        check("R8", "irq masked", irq_out, 0);
        rd_addr = 3; #1;
        check("R9", "unmapped offset reads zero", rd_data, 0);
        tick();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule